// File: doc/BRIEF.md
# Serial Interrupt Peripheral Agent

This block is the peripheral end of a single-wire, open-drain serial interrupt line that a host and several agents share. It has no view of the host's state. It follows the line itself: it measures each low run, recognises the pulse that opens a cycle, and then counts three-clock frames (sample, recovery, turn-around) from the clock on which the line goes high again. When a frame assigned to one of its local interrupt sources reaches its sample phase, the agent pulls the line low if that source is asserted. It then drives the line high for one clock so that the line recovers, and releases it.

The agent also learns the line's operating mode from the width of the low pulse that ends each cycle. In quiet mode the host does not start cycles unless it is asked to. When a local source has changed since the agent last reported it, the agent requests a cycle by pulling the idle line low for one clock, and the host then completes the start pulse. Each local source is given its frame number by a map input. A map value that is out of range leaves that source unassigned.

Top module: `sirq_agent`

## Requirements
- R1: During reset and after it, drive_en is 0. The agent comes out of reset in continuous mode, so an asserted source does not make it drive the idle line.
- R2: Outside the data frames, a low run of START_MIN to START_MAX clocks followed by a high clock opens a cycle. That high clock is clock 0. Data frame k has its sample phase on clock 3k+2, its recovery on clock 3k+3 and its turn-around on clock 3k+4, for k = 0 to NUM_FRAMES-1.
- R3: An idle low run shorter than START_MIN clocks, or longer than START_MAX clocks, does not open a cycle. No frame is driven after it.
- R4: In the sample clock of frame k, the agent drives the line low (drive_en=1, drive_low=1) if some source s has a map field frame_map[s*FIDX_W +: FIDX_W] equal to k and irq_in[s] is 1. If no such source is asserted, the agent does not drive.
- R5: After a sample clock in which it drove low, the agent drives high (drive_en=1, drive_low=0) for the recovery clock. It releases the line (drive_en=0) in the turn-around clock.
- R6: A source whose map value is NUM_FRAMES or more is never driven in any frame. Every clock that is not an owned sample or the recovery after one has drive_en=0.
- R7: Each source's input is sampled once per cycle, at the clock edge that opens its sample clock. A change during the sample clock does not affect what is sent.
- R8: After the data frames, a low run of QUIET_W clocks selects quiet mode and a low run of CONT_W clocks selects continuous mode. The mode takes effect on the first high clock after the run.
- R9: In quiet mode, once the idle line has been high for IDLE_MIN clocks, the agent drives it low for exactly one clock if an assigned source differs from the level that source last reported in a frame.
- R10: The agent requests no cycle in continuous mode, or when the only differences are on unassigned sources.
- R11: Lows that other drivers place on the line during the data frames do not shift frame counting and do not change the mode, even when their widths match a stop or start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Synchronous sample of the shared interrupt line |
| irq_in | input | NUM_SRC | Local interrupt sources, active high |
| frame_map | input | NUM_SRC*FIDX_W | Frame number of each source. Source s uses bits s*FIDX_W upward |
| drive_en | output | 1 | The agent drives the line in this clock |
| drive_low | output | 1 | Level driven when drive_en is 1: 1 = low, 0 = high |

## Verification
The bench builds the agent with three sources and six data frames, so each cycle takes 20 clocks. Source 0 is mapped to frame 1, source 1 to frame 4, and source 2 to frame 6, which is out of range and so unassigned. With these values, start pulses at both width limits, non-start widths on each side of those limits, and frame-internal lows shaped like stop and start pulses all fit within a few hundred clocks. The bench closes the loop through a wired-AND line model, so an agent-initiated cycle runs to completion with the host finishing the start pulse.

// File: rtl/sirq_agent_pkg.sv
package sirq_agent_pkg;

    typedef enum logic [1:0] {
        PH_SAMPLE = 2'd0,
        PH_RECOV  = 2'd1,
        PH_TURN   = 2'd2
    } phase_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_FRAMES = 1'b1
    } state_e;

    typedef enum logic [1:0] {
        PC_NONE  = 2'd0,
        PC_START = 2'd1,
        PC_QUIET = 2'd2,
        PC_CONT  = 2'd3
    } pulse_e;

endpackage

// File: rtl/sirq_pulse_class.sv
// Classifies a finished low run on the idle line by its width.
module sirq_pulse_class
    import sirq_agent_pkg::*;
#(
    parameter int RUN_W     = 4,
    parameter int START_MIN = 4,
    parameter int START_MAX = 8,
    parameter int QUIET_W   = 2,
    parameter int CONT_W    = 3
) (
    input  logic [RUN_W-1:0] low_run,
    output pulse_e           kind
);

    always_comb begin
        if (low_run >= RUN_W'(START_MIN) && low_run <= RUN_W'(START_MAX)) begin
            kind = PC_START;
        end else if (low_run == RUN_W'(QUIET_W)) begin
            kind = PC_QUIET;
        end else if (low_run == RUN_W'(CONT_W)) begin
            kind = PC_CONT;
        end else begin
            kind = PC_NONE;
        end
    end

endmodule

// File: rtl/sirq_src_match.sv
// Per-source decode of the frame map: which sources own a frame, which are assigned.
module sirq_src_match #(
    parameter int NUM_SRC    = 4,
    parameter int NUM_FRAMES = 17,
    parameter int FIDX_W     = 5
) (
    input  logic [NUM_SRC*FIDX_W-1:0] frame_map,
    input  logic [FIDX_W-1:0]         frame_idx,
    output logic [NUM_SRC-1:0]        hit,
    output logic [NUM_SRC-1:0]        assigned
);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        logic [FIDX_W-1:0] slot;
        assign slot        = frame_map[s*FIDX_W +: FIDX_W];
        assign assigned[s] = (slot < FIDX_W'(NUM_FRAMES));
        assign hit[s]      = assigned[s] && (slot == frame_idx);
    end

endmodule

// File: rtl/sirq_change_det.sv
// Flags an assigned source whose level differs from what it last reported.
module sirq_change_det #(
    parameter int NUM_SRC = 4
) (
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [NUM_SRC-1:0] reported,
    input  logic [NUM_SRC-1:0] assigned,
    output logic               pending
);

    logic [NUM_SRC-1:0] diff;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_cmp
        assign diff[s] = assigned[s] && (irq_in[s] != reported[s]);
    end

    assign pending = |diff;

endmodule

// File: rtl/sirq_agent.sv
module sirq_agent
    import sirq_agent_pkg::*;
#(
    parameter int NUM_SRC    = 4,
    parameter int NUM_FRAMES = 17,
    parameter int START_MIN  = 4,
    parameter int START_MAX  = 8,
    parameter int QUIET_W    = 2,
    parameter int CONT_W     = 3,
    parameter int IDLE_MIN   = 2,
    localparam int FIDX_W    = $clog2(NUM_FRAMES + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      line_in,
    input  logic [NUM_SRC-1:0]        irq_in,
    input  logic [NUM_SRC*FIDX_W-1:0] frame_map,
    output logic                      drive_en,
    output logic                      drive_low
);

    localparam int RUN_SAT = START_MAX + 1;
    localparam int RUN_W   = $clog2(RUN_SAT + 1);
    localparam int HI_W    = $clog2(IDLE_MIN + 1);

    typedef struct packed {
        state_e             state;
        phase_e             phase;
        logic [FIDX_W-1:0]  fcnt;      // 0 = start frame, k+1 = data frame k
        logic [RUN_W-1:0]   low_run;
        logic [HI_W-1:0]    high_run;
        logic               quiet;
        logic [NUM_SRC-1:0] reported;
        logic               drv_en;
        logic               drv_low;
    } agent_s;

    agent_s st_d, st_q;

    pulse_e             pulse_kind;
    logic [NUM_SRC-1:0] src_hit;
    logic [NUM_SRC-1:0] src_assigned;
    logic               req_pending;
    logic [RUN_W-1:0]   low_inc;
    logic [HI_W-1:0]    high_inc;

    sirq_pulse_class #(
        .RUN_W    (RUN_W),
        .START_MIN(START_MIN),
        .START_MAX(START_MAX),
        .QUIET_W  (QUIET_W),
        .CONT_W   (CONT_W)
    ) i_pulse_class (
        .low_run(st_q.low_run),
        .kind   (pulse_kind)
    );

    // Index of the data frame whose sample phase opens on the next edge.
    sirq_src_match #(
        .NUM_SRC   (NUM_SRC),
        .NUM_FRAMES(NUM_FRAMES),
        .FIDX_W    (FIDX_W)
    ) i_src_match (
        .frame_map(frame_map),
        .frame_idx(st_q.fcnt),
        .hit      (src_hit),
        .assigned (src_assigned)
    );

    sirq_change_det #(
        .NUM_SRC(NUM_SRC)
    ) i_change_det (
        .irq_in  (irq_in),
        .reported(st_q.reported),
        .assigned(src_assigned),
        .pending (req_pending)
    );

    always_comb begin
        st_d         = st_q;
        st_d.drv_en  = 1'b0;
        st_d.drv_low = 1'b0;

        low_inc  = (st_q.low_run == RUN_W'(RUN_SAT)) ? st_q.low_run : st_q.low_run + RUN_W'(1);
        high_inc = (st_q.high_run == HI_W'(IDLE_MIN)) ? st_q.high_run : st_q.high_run + HI_W'(1);

        case (st_q.state)
            ST_IDLE: begin
                if (line_in) begin
                    st_d.low_run  = '0;
                    st_d.high_run = high_inc;
                    case (pulse_kind)
                        PC_START: begin
                            st_d.state    = ST_FRAMES;
                            st_d.phase    = PH_TURN;
                            st_d.fcnt     = '0;
                            st_d.high_run = '0;
                        end
                        PC_QUIET: st_d.quiet = 1'b1;
                        PC_CONT:  st_d.quiet = 1'b0;
                        default:  ;
                    endcase
                    if (st_d.state == ST_IDLE && st_d.quiet &&
                        st_d.high_run >= HI_W'(IDLE_MIN) && req_pending) begin
                        st_d.drv_en  = 1'b1;
                        st_d.drv_low = 1'b1;
                    end
                end else begin
                    st_d.low_run  = low_inc;
                    st_d.high_run = '0;
                end
            end
            ST_FRAMES: begin
                case (st_q.phase)
                    PH_TURN: begin
                        if (st_q.fcnt == FIDX_W'(NUM_FRAMES)) begin
                            st_d.state    = ST_IDLE;
                            st_d.low_run  = '0;
                            st_d.high_run = '0;
                        end else begin
                            st_d.phase    = PH_SAMPLE;
                            st_d.fcnt     = st_q.fcnt + FIDX_W'(1);
                            st_d.reported = (st_q.reported & ~src_hit) | (irq_in & src_hit);
                            st_d.drv_en   = |(src_hit & irq_in);
                            st_d.drv_low  = |(src_hit & irq_in);
                        end
                    end
                    PH_SAMPLE: begin
                        st_d.phase  = PH_RECOV;
                        st_d.drv_en = st_q.drv_low;
                    end
                    default: begin
                        st_d.phase = PH_TURN;
                    end
                endcase
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, phase: PH_TURN, fcnt: '0, low_run: '0,
                      high_run: '0, quiet: 1'b0, reported: '0,
                      drv_en: 1'b0, drv_low: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign drive_en  = st_q.drv_en;
    assign drive_low = st_q.drv_low;

    logic frames_active;
    logic turn_phase;
    logic quiet_now;
    assign frames_active = (st_q.state == ST_FRAMES);
    assign turn_phase    = frames_active && (st_q.phase == PH_TURN);
    assign quiet_now     = st_q.quiet;

endmodule

// File: rtl/sirq_agent_chk.sv
module sirq_agent_chk (
    input logic clk,
    input logic rst_n,
    input logic drive_en,
    input logic drive_low,
    input logic frames_active,
    input logic turn_phase,
    input logic quiet_now
);

    // R4: a low level is only ever presented while driving
    p_low_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        drive_low |-> drive_en);

    // R5: a low sample inside the frames is followed by a driven high
    p_recovery_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frames_active && drive_en && drive_low) |=> (drive_en && !drive_low));

    // R5: the driven high lasts one clock
    p_release_after_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && !drive_low) |=> !drive_en);

    // R6: turn-around clocks are always released
    p_turn_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        turn_phase |-> !drive_en);

    // R10: no request on the idle line in continuous mode
    p_cont_no_request_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!frames_active && !quiet_now) |-> !drive_en);

    // R9: a request lasts a single clock
    p_request_one_clock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!frames_active && drive_en) |=> !drive_en);

endmodule

bind sirq_agent sirq_agent_chk i_sirq_agent_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .drive_en     (drive_en),
    .drive_low    (drive_low),
    .frames_active(frames_active),
    .turn_phase   (turn_phase),
    .quiet_now    (quiet_now)
);

// File: tb/test_sirq_agent.sv
module test_sirq_agent;

    localparam int NSRC   = 3;
    localparam int NFR    = 6;
    localparam int FW     = $clog2(NFR + 1);
    localparam int LAST_C = 3 * NFR + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_low = 1'b0;
    logic [NSRC-1:0] irq = '0;
    logic [NSRC*FW-1:0] fmap;
    logic drive_en, drive_low;
    logic line;

    int checks = 0;
    int failures = 0;
    int exp_drv [0:63];
    bit finished = 1'b0;

    // src0 -> frame 1, src1 -> frame 4, src2 -> frame 6 (unassigned)
    assign fmap = {FW'(6), FW'(4), FW'(1)};
    assign line = !(host_low || (drive_en && drive_low));

    always #5 clk = ~clk;

    sirq_agent #(
        .NUM_SRC   (NSRC),
        .NUM_FRAMES(NFR)
    ) i_sirq_agent (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (line),
        .irq_in   (irq),
        .frame_map(fmap),
        .drive_en (drive_en),
        .drive_low(drive_low)
    );

    function automatic int drv_code();
        return drive_en ? (drive_low ? 2 : 1) : 0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv, input string what);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic clear_exp();
        for (int i = 0; i < 64; i++) exp_drv[i] = 0;
    endtask

    task automatic own_frame(input int k);
        exp_drv[3*k+2] = 2;
        exp_drv[3*k+3] = 1;
    endtask

    task automatic idle_quiet(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            host_low = 1'b0;
            chk(drive_en == 1'b0, req, drive_en, 0, "idle drive_en");
        end
    endtask

    // Host runs one cycle: start pulse, data frames (checked per clock), stop pulse.
    task automatic host_cycle(input int start_w, input int stop_w,
                              input int c1, input logic [NSRC-1:0] v1,
                              input int c2, input logic [NSRC-1:0] v2,
                              input logic [63:0] extra_low, input string req);
        for (int i = 0; i < start_w; i++) begin
            @(negedge clk);
            host_low = 1'b1;
        end
        for (int c = 0; c <= LAST_C; c++) begin
            @(negedge clk);
            host_low = extra_low[c];
            chk(drv_code() == exp_drv[c], req, drv_code(), exp_drv[c], $sformatf("clock %0d drive", c));
            if (c == c1) irq = v1;
            if (c == c2) irq = v2;
        end
        for (int i = 0; i < stop_w; i++) begin
            @(negedge clk);
            host_low = 1'b1;
        end
        idle_quiet(2, req);
    endtask

    task automatic t_reset();
        irq = 3'b001;
        @(negedge clk);
        chk(drive_en == 1'b0, "R1", drive_en, 0, "drive_en in reset");
        rst_n = 1'b1;
        idle_quiet(8, "R1");
        irq = '0;
    endtask

    task automatic t_basic();
        irq = 3'b101;
        clear_exp();
        own_frame(1);
        host_cycle(4, 3, -1, '0, -1, '0, 64'd0, "R2_R4_R5_R6");
    endtask

    task automatic t_wide_start();
        irq = 3'b010;
        clear_exp();
        own_frame(4);
        host_cycle(8, 3, -1, '0, -1, '0, 64'd0, "R2_R4");
    endtask

    task automatic t_sample_once();
        irq = 3'b000;
        clear_exp();
        own_frame(1);
        host_cycle(4, 3, 4, 3'b001, 14, 3'b010, 64'd0, "R7");
    endtask

    task automatic t_non_start();
        irq = 3'b011;
        for (int i = 0; i < 3; i++) begin @(negedge clk); host_low = 1'b1; end
        idle_quiet(3, "R3");
        for (int i = 0; i < 10; i++) begin @(negedge clk); host_low = 1'b1; end
        idle_quiet(22, "R3");
    endtask

    task automatic t_foreign_lows();
        logic [63:0] xl;
        xl = '0;
        xl[2] = 1'b1;
        xl[3] = 1'b1;
        for (int c = 8; c <= 12; c++) xl[c] = 1'b1;
        irq = 3'b011;
        clear_exp();
        own_frame(1);
        own_frame(4);
        host_cycle(4, 3, -1, '0, -1, '0, xl, "R11");
        irq = 3'b000;
        idle_quiet(6, "R8_R10");
    endtask

    task automatic t_quiet_request();
        irq = 3'b000;
        clear_exp();
        host_cycle(5, 2, -1, '0, -1, '0, 64'd0, "R8");
        idle_quiet(4, "R10");
        irq = 3'b100;
        idle_quiet(4, "R10");
        irq = 3'b010;
        @(negedge clk);
        chk(drv_code() == 2, "R9", drv_code(), 2, "request drives low");
        host_low = 1'b1;
        @(negedge clk);
        chk(drive_en == 1'b0, "R9", drive_en, 0, "request released");
        host_low = 1'b1;
        clear_exp();
        own_frame(4);
        host_cycle(2, 2, -1, '0, -1, '0, 64'd0, "R9");
        idle_quiet(6, "R10");
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_wide_start();
        t_sample_once();
        t_non_start();
        t_foreign_lows();
        t_quiet_request();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule